// File: doc/BRIEF.md
# Double to Half Precision Converter

This block turns one IEEE-754 binary64 operand into the nearest binary16 value, rounding to nearest with ties going to the even result. Before any rounding takes place, every fraction bit below the half-precision guard position collapses into a single sticky bit. The final step then needs only a three-bit pattern: the kept LSB, the guard bit and the sticky bit. Results that fall below the normal range come out as subnormals, or as zero. Magnitudes too large for binary16 saturate to infinity. An infinite input stays infinite, and any NaN input becomes the canonical quiet NaN.

Operands come in on a valid/ready stream, and results leave on another one. The parameter `PIPE_STAGES` picks one or two register stages. The pipeline advances as a unit. It stalls only when the output holds a result that the consumer has not taken. While it is stalled, the output holds its value and `in_ready` is low. In every other cycle one operand can enter. A producer must keep `in_data` steady while `in_valid` is high and `in_ready` is low.

Top module: `d2h_convert`

## Requirements
- R1: Output bit 15 always equals input bit 63, including for zero, infinity and NaN inputs.
- R2: An input whose binary16 result is a normal number produces the nearest half value. On an exact tie, the result with an even last bit is chosen. Any nonzero bit in the lower input word breaks a tie upward.
- R3: An input below the smallest normal half (2^-14) produces a correctly rounded subnormal (exponent field 0). A value that rounds up to 2^-14 produces 0x0400. Anything at or below half of 2^-24 produces signed zero.
- R4: A finite input whose rounded magnitude reaches 2^16 or more produces magnitude 0x7c00 (infinity). This includes 65520, which rounds up from the largest finite half, 65504 (magnitude 0x7bff). A result that is not a NaN never has a magnitude above 0x7c00.
- R5: An input with exponent field 0x7ff and zero fraction produces magnitude 0x7c00.
- R6: An input with exponent field 0x7ff and any nonzero fraction bit produces magnitude 0x7e00. This holds even when the nonzero bits lie only in the lower 32 bits.
- R7: While `out_ready` stays high, an operand accepted at a clock edge appears on `out_valid`/`out_data` exactly `PIPE_STAGES` edges later.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R9: After reset, `out_valid` is low. `in_ready` is high whenever `out_valid` is low.
- R10: For a normal result with rebiased exponent e (1 to 30), the output exponent field is e or e+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Converter can take an operand this cycle |
| in_data | input | 64 | binary64 operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 16 | binary16 result |

## Verification
Random operands almost never land on the cases that matter. These are exact rounding ties, ties broken only by a bit in the lower word, subnormals that round up into the normal range, and NaNs whose payload sits only in the lower word. The bench therefore starts with a directed list of exact bit patterns for these points. It then sends random operands whose exponents mostly cluster around the half-precision range. Stalls on the output side are hard to line up with data that is still in flight. To create them, the second phase drops `out_ready` at random while the input valid toggles, so results pile up behind a stalled output.

// File: rtl/d2h_pkg.sv
package d2h_pkg;
  localparam int SRC_W      = 64;
  localparam int WORD_W     = 32;
  localparam int DST_W      = 16;
  localparam int SRC_EXP_W  = 11;
  localparam int SRC_BIAS   = 1023;
  localparam int DST_BIAS   = 15;
  localparam int REBIAS     = SRC_BIAS - DST_BIAS;
  localparam int EXP_W      = 13;              // signed rebiased exponent
  localparam int WMANT_W    = 12;              // 10 kept + guard + sticky
  localparam int PRE_W      = 17;              // exponent(5) over working mantissa
  localparam int SHMAX      = 13;
  localparam int EXP_ALL1   = (1 << SRC_EXP_W) - 1 - REBIAS;  // 1039
  localparam int EXP_NMAX   = 30;
  localparam logic [DST_W-2:0] MAG_INF  = 15'h7c00;
  localparam logic [DST_W-2:0] MAG_QNAN = 15'h0200;

  typedef struct packed {
    logic                     sign;
    logic signed [EXP_W-1:0]  exp;
    logic [WMANT_W-1:0]       mant;
  } d2h_fields_t;
endpackage

// File: rtl/d2h_unpack.sv
module d2h_unpack
  import d2h_pkg::*;
(
  input  logic [WORD_W-1:0] hi_word,
  input  logic [WORD_W-1:0] lo_word,
  output d2h_fields_t       fields
);
  localparam int EXP_LSB = WORD_W - 1 - SRC_EXP_W;   // 20
  localparam int KEEP_LSB = EXP_LSB - (WMANT_W - 1); // 9

  logic [SRC_EXP_W-1:0] raw_exp;
  logic                 sticky;

  always_comb begin
    raw_exp       = hi_word[WORD_W-2 -: SRC_EXP_W];
    sticky        = (|hi_word[KEEP_LSB-1:0]) | (|lo_word);
    fields.sign   = hi_word[WORD_W-1];
    fields.exp    = $signed({{(EXP_W-SRC_EXP_W){1'b0}}, raw_exp}) - EXP_W'(REBIAS);
    fields.mant   = {hi_word[EXP_LSB-1:KEEP_LSB], sticky};
  end
endmodule

// File: rtl/d2h_align.sv
module d2h_align
  import d2h_pkg::*;
(
  input  d2h_fields_t       fields,
  output logic [PRE_W-1:0]  pre
);
  localparam int SIG_W = WMANT_W + 1;

  logic signed [EXP_W:0] diff;
  logic [3:0]            shamt;
  logic [SIG_W-1:0]      full_sig;
  logic [SIG_W-1:0]      shifted;
  logic                  lost;

  always_comb begin
    diff = $signed(14'sd1) - {fields.exp[EXP_W-1], fields.exp};
    if (diff > 14'sd13)      shamt = 4'(SHMAX);
    else if (diff < 14'sd0)  shamt = 4'd0;
    else                     shamt = diff[3:0];
    full_sig = {1'b1, fields.mant};
    shifted  = full_sig >> shamt;
    lost     = (shifted << shamt) != full_sig;
    if (fields.exp < 13'sd1)
      pre = {{(PRE_W-SIG_W){1'b0}}, shifted[SIG_W-1:1], shifted[0] | lost};
    else
      pre = {fields.exp[4:0], fields.mant};
  end
endmodule

// File: rtl/d2h_round.sv
module d2h_round
  import d2h_pkg::*;
(
  input  d2h_fields_t       fields,
  input  logic [PRE_W-1:0]  pre,
  output logic [DST_W-1:0]  result
);
  logic                 bump;
  logic [DST_W-2:0]     rounded;
  logic [DST_W-2:0]     mag;

  always_comb begin
    bump    = (pre[2:0] == 3'd3) || (pre[2:0] > 3'd5);
    rounded = pre[PRE_W-1:2] + 15'(bump);
    if (fields.exp == 13'(EXP_ALL1))
      mag = MAG_INF | ((fields.mant != '0) ? MAG_QNAN : '0);
    else if (fields.exp > 13'sd30)
      mag = MAG_INF;
    else
      mag = rounded;
    result = {fields.sign, mag};
  end

  always_comb begin
    if (fields.exp != 13'(EXP_ALL1)) begin
      // R4
      nonan_mag_chk: assert (mag <= MAG_INF);
    end
    if (fields.exp >= 13'sd1 && fields.exp <= 13'sd30) begin
      // R10
      exp_step_chk: assert (mag[14:10] == fields.exp[4:0] ||
                            mag[14:10] == fields.exp[4:0] + 5'd1);
    end
  end
endmodule

// File: rtl/d2h_convert.sv
module d2h_convert
  import d2h_pkg::*;
#(
  parameter int PIPE_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SRC_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DST_W-1:0] out_data
);
  logic         stall;
  d2h_fields_t  in_fields;
  d2h_fields_t  rnd_fields;
  logic         rnd_valid;
  logic [PRE_W-1:0] pre;
  logic [DST_W-1:0] result;

  assign stall    = out_valid & ~out_ready;
  assign in_ready = ~stall;

  d2h_unpack u_unpack (
    .hi_word (in_data[SRC_W-1:WORD_W]),
    .lo_word (in_data[WORD_W-1:0]),
    .fields  (in_fields)
  );

  generate
    if (PIPE_STAGES >= 2) begin : g_two
      d2h_fields_t s1_fields;
      logic        s1_valid;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_valid  <= 1'b0;
          s1_fields <= '0;
        end else if (!stall) begin
          s1_valid  <= in_valid;
          s1_fields <= in_fields;
        end
      end
      assign rnd_fields = s1_fields;
      assign rnd_valid  = s1_valid;
    end else begin : g_one
      assign rnd_fields = in_fields;
      assign rnd_valid  = in_valid;
    end
  endgenerate

  d2h_align u_align (
    .fields (rnd_fields),
    .pre    (pre)
  );

  d2h_round u_round (
    .fields (rnd_fields),
    .pre    (pre),
    .result (result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (!stall) begin
      out_valid <= rnd_valid;
      out_data  <= result;
    end
  end

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  empty_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(rnd_valid));
endmodule

// File: tb/tb_d2h_convert.sv
module tb_d2h_convert;
  localparam int PIPE   = 1;
  localparam int NRAND  = 700;
  localparam int LIMIT  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;

  always #4 clk = ~clk;

  d2h_convert #(.PIPE_STAGES(PIPE)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [15:0] ref_half(input logic [63:0] x);
    longint unsigned sig, q, rem, halfw, mag;
    int ex, e, he, sh;
    ex = int'(x[62:52]);
    if (ex == 2047) return {x[63], (x[51:0] != 0) ? 15'h7e00 : 15'h7c00};
    sig = (ex == 0) ? longint'(x[51:0]) : (longint'(x[51:0]) | (64'd1 << 52));
    e  = (ex == 0) ? -1022 : ex - 1023;
    he = e + 15;
    sh = (he >= 1) ? 42 : 43 - he;
    if (sh > 60) sh = 60;
    q     = sig >> sh;
    rem   = sig & ((64'd1 << sh) - 1);
    halfw = 64'd1 << (sh - 1);
    if (rem > halfw || (rem == halfw && q[0])) q = q + 1;
    if (he >= 1) mag = (longint'(he - 1) << 10) + q;
    else         mag = q;
    if (mag >= 64'h7c00) mag = 64'h7c00;
    return {x[63], mag[14:0]};
  endfunction

  function automatic string tag_of(input logic [63:0] x, input logic [15:0] r);
    if (x[62:52] == 11'h7ff) return (x[51:0] != 0) ? "R6" : "R5";
    if (r[14:0] == 15'h7c00) return "R4";
    if (r[14:10] == 5'd0)    return "R3";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  logic [63:0] vecs[$];
  logic [63:0] inq[$];
  int          accq[$];
  int          n_dir;

  initial begin
    // R1 R2 R3 R4 R5 R6 directed corner operands
    vecs.push_back(64'h0000000000000000);   // +0
    vecs.push_back(64'h8000000000000000);   // -0
    vecs.push_back(64'h40EFFC0000000000);   // 65504
    vecs.push_back(64'h40EFFBFFFFFFFFFF);   // just below 65504
    vecs.push_back(64'h40EFFE0000000000);   // 65520 tie -> inf
    vecs.push_back(64'hC0EFFE0000000000);   // -65520
    vecs.push_back(64'h40EFFDFFFFFFFFFF);   // below tie -> max
    vecs.push_back(64'h3E70000000000000);   // 2^-24
    vecs.push_back(64'h3E60000000000000);   // 2^-25 tie -> 0
    vecs.push_back(64'h3E60000000000001);   // above tie -> min sub
    vecs.push_back(64'h3E78000000000000);   // 1.5*2^-24 tie -> 2
    vecs.push_back(64'h3F10000000000000);   // 2^-14
    vecs.push_back(64'h3F0FFFFFFFFFFFFF);   // rounds up into normal
    vecs.push_back(64'h3FF0020000000000);   // tie, even down
    vecs.push_back(64'h3FF0060000000000);   // tie, odd up
    vecs.push_back(64'h3FF0020000000001);   // tie broken by low word
    vecs.push_back(64'h3FF0000000000000);   // 1.0
    vecs.push_back(64'h7FF0000000000000);   // +inf
    vecs.push_back(64'hFFF0000000000000);   // -inf
    vecs.push_back(64'h7FF0000000000001);   // NaN, low word payload
    vecs.push_back(64'hFFF0000000000100);   // -NaN, low word payload
    vecs.push_back(64'h7FF8000000000000);   // quiet NaN
    vecs.push_back(64'h7E37E43C8800759C);   // 1e300
    vecs.push_back(64'h0000000000000001);   // double subnormal
    vecs.push_back(64'h3E50000000000000);   // 2^-26 -> 0
    n_dir = vecs.size();
    for (int i = 0; i < NRAND; i++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      if ($urandom % 4 != 0) r[62:52] = 11'(985 + $urandom % 64);
      if ($urandom % 8 == 0) r[31:0] = '0;
      vecs.push_back(r);
    end
  end

  initial begin
    int idx = 0, cyc = 0;
    bit hold_in = 0, prev_stall = 0, stall_seen = 0;
    logic [15:0] prev_data = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R9", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    forever begin
      @(negedge clk);
      if (!hold_in) begin
        if (idx < vecs.size() && (idx < n_dir || $urandom % 4 != 0)) begin
          in_valid = 1'b1;
          in_data  = vecs[idx];
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = (idx < n_dir) ? 1'b1 : ($urandom % 10 < 7);
      #1;
      if (prev_stall) begin
        // R8 output held under back-pressure
        check("R8", {47'd0, out_valid, out_data}, {47'd0, 1'b1, prev_data});
      end
      if (!out_valid) check("R9", 64'(in_ready), 64'd1);
      if (out_valid && out_ready) begin
        if (inq.size() == 0) begin
          check("R7", 64'd1, 64'd0);
        end else begin
          logic [63:0] x;
          logic [15:0] e16;
          int a;
          x = inq.pop_front();
          a = accq.pop_front();
          e16 = ref_half(x);
          check(tag_of(x, e16), 64'(out_data), 64'(e16));
          // R1 sign carried through
          check("R1", 64'(out_data[15]), 64'(x[63]));
          if (!stall_seen) check("R7", 64'(cyc - a), 64'(PIPE));
        end
      end
      if (in_valid && in_ready) begin
        inq.push_back(in_data);
        accq.push_back(cyc);
        idx++;
        hold_in = 0;
      end else begin
        hold_in = in_valid;
      end
      prev_stall = out_valid && !out_ready;
      if (prev_stall) stall_seen = 1;
      prev_data  = out_data;
      cyc++;
      if (idx >= vecs.size() && inq.size() == 0 && !out_valid && !in_valid) break;
      if (cyc > LIMIT) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, LIMIT);
        break;
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule